// File: doc/BRIEF.md
# System Configuration Port Handler

This block sits behind a three-port parallel peripheral interface in a personal computer and gives its ports their meaning. A write to the control port (port B) is held in a register. The block decodes that register into a two-bit keyboard mode, a keyboard read enable, a select between the two switch banks, and the gate and data-enable bits for the speaker. A read of port A returns the byte from the keyboard when keyboard reads are enabled. When they are disabled, it returns both configuration switch nibbles. A read of port C returns the selected nibble.

The two nibbles come from parameters: the drive count, the video mode, the on-board RAM size and whether a math coprocessor is fitted. The block keeps an observed flag that is set once software has seen the high nibble. Until then, a display hint can swap a color video setting between its 40-column (composite) and 80-column forms. The keyboard controller and the tone generator sit outside this block and connect to the outputs.

Top module: `sys_cfg_port`

## Requirements
- R1: After reset the control register is 8'h00, so port B reads 8'h00, the keyboard mode output is 2'b00, both speaker outputs are 0 and the observed flag is clear.
- R2: A write to port B (select 2'd1) is read back unchanged from port B. The keyboard mode output is bits 7..6 of that write, the speaker gate is bit 0 and the speaker data enable is bit 1.
- R3: When control bit 7 is 0, a read of port A (select 2'd0) returns the keyboard data input, and the keyboard read strobe is high in that same cycle.
- R4: When control bit 7 is 1, a read of port A returns the high nibble in bits 7..4 and the low nibble in bits 3..0, and the keyboard read strobe stays low.
- R5: The high nibble carries the drive count minus one in bits 3..2. It carries the video code in bits 1..0: 00 none, 01 color 40-column, 10 color 80-column, 11 monochrome.
- R6: The low nibble carries the RAM size code in bits 3..2, coprocessor present in bit 1 and floppy present in bit 0. Bit 0 is 1 when the drive count is nonzero.
- R7: A read of port C (select 2'd2) returns 4'b0000 in bits 7..4. Bits 3..0 hold the high nibble when control bit 3 is 1 and the low nibble when it is 0.
- R8: Every read of port A sets the observed flag. A read of port C sets it only when control bit 3 is 1.
- R9: A hint sets the video code to 01 if composite and to 10 otherwise. It takes effect only when the observed flag is clear and the video code is 01 or 10. A hint in the same cycle as a flag-setting read still takes effect. Once the flag is set, or when the code is 00 or 11, the hint is ignored.
- R10: Writes to port A or port C change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Port select: 0 = A, 1 = B, 2 = C |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| kbd_byte | input | 8 | Byte presented by the keyboard controller |
| kbd_take | output | 1 | High when port A returns the keyboard byte |
| kbd_mode | output | 2 | Keyboard mode, control bits 7..6 |
| spk_gate | output | 1 | Speaker timer gate |
| spk_data_en | output | 1 | Speaker data enable |
| hint_valid | input | 1 | Display hint strobe |
| hint_composite | input | 1 | 1 = composite display, 0 = color monitor |

## Verification
The assertions assume that the bus raises at most one of bus_wr and bus_rd in a cycle and that each strobe lasts a single cycle. The bench drives every access as a one-cycle pulse and leaves a cycle between accesses. The hint is treated as an independent strobe. The bench applies it both before and after flag-setting reads, with the reset repeated, so each ordering starts from a clear flag. A second instance configured for a monochrome adapter checks that a hint has no effect on that setting.

// File: rtl/sys_cfg_pkg.sv
// Shared encodings for the system configuration port handler.
// Assumes an 8-bit port interface with three decoded ports.
package sys_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        PSEL_A    = 2'd0,
        PSEL_B    = 2'd1,
        PSEL_C    = 2'd2,
        PSEL_NONE = 2'd3
    } port_sel_e;

    typedef enum logic [1:0] {
        VID_NONE  = 2'b00,
        VID_CLR40 = 2'b01,
        VID_CLR80 = 2'b10,
        VID_MONO  = 2'b11
    } video_code_e;

    // Decoded view of the control register.
    typedef struct packed {
        logic [1:0] kbd_mode;
        logic       kbd_disable;
        logic       sel_high;
        logic       spk_gate;
        logic       spk_data_en;
    } ctrl_view_t;
endpackage

// File: rtl/sys_cfg_ctrl_reg.sv
// Control register: holds the last port-B write and decodes its fields.
// Assumes single-cycle write strobes. Writes to other ports are ignored here.
module sys_cfg_ctrl_reg
    import sys_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_b,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctrl_q,
    output ctrl_view_t        view
);
    localparam int KBD_DIS_BIT = 7;
    localparam int SEL_HI_BIT  = 3;
    localparam int GATE_BIT    = 0;
    localparam int DATA_BIT    = 1;

    // Capture port B writes.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctrl_q <= '0;
        else if (wr_b) ctrl_q <= wdata;
    end

    // Split the register into named fields.
    always_comb begin
        view.kbd_mode    = ctrl_q[KBD_DIS_BIT -: 2];
        view.kbd_disable = ctrl_q[KBD_DIS_BIT];
        view.sel_high    = ctrl_q[SEL_HI_BIT];
        view.spk_gate    = ctrl_q[GATE_BIT];
        view.spk_data_en = ctrl_q[DATA_BIT];
    end

    // R2
    ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> ctrl_q == $past(wdata));
    // R10
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_b |=> $stable(ctrl_q));
endmodule

// File: rtl/sys_cfg_switches.sv
// Switch banks: builds both nibbles from parameters and tracks the observed flag.
// Assumes the read strobes are already decoded. Handles the late display hint.
module sys_cfg_switches
    import sys_cfg_pkg::*;
#(
    parameter int         DRIVES    = 2,
    parameter logic [1:0] VIDEO     = 2'b10,
    parameter logic [1:0] RAM_CODE  = 2'b11,
    parameter bit         HAS_FPU   = 1'b0
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             see_high,
    input  logic             hint_valid,
    input  logic             hint_composite,
    output logic [NIB_W-1:0] high_nib,
    output logic [NIB_W-1:0] low_nib,
    output logic             observed
);
    localparam logic [1:0] DRV_CODE   = (DRIVES > 0) ? 2'(DRIVES - 1) : 2'b00;
    localparam bit         HAS_FLOPPY = (DRIVES > 0);

    logic [1:0] video_q;
    logic       hint_ok;

    assign hint_ok  = hint_valid && !observed &&
                      (video_q == VID_CLR40 || video_q == VID_CLR80);
    assign high_nib = {DRV_CODE, video_q};
    assign low_nib  = {RAM_CODE, HAS_FPU, HAS_FLOPPY};

    // Video code, rewritten by an accepted hint.
    always_ff @(posedge clk) begin
        if (!rst_n)       video_q <= VIDEO;
        else if (hint_ok) video_q <= hint_composite ? VID_CLR40 : VID_CLR80;
    end

    // Observed flag stays set until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        observed <= 1'b0;
        else if (see_high) observed <= 1'b1;
    end

    // R8
    obs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        observed |=> observed);
    // R9
    video_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        observed |=> $stable(video_q));
    // R9
    video_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (video_q == VID_NONE || video_q == VID_MONO) |=> $stable(video_q));
endmodule

// File: rtl/sys_cfg_read_mux.sv
// Read path: selects the byte returned for each port and flags keyboard reads.
// Purely combinational. Assumes that the nibbles and the control view are registered.
module sys_cfg_read_mux
    import sys_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] ctrl_q,
    input  ctrl_view_t        view,
    input  logic [NIB_W-1:0]  high_nib,
    input  logic [NIB_W-1:0]  low_nib,
    input  logic [BYTE_W-1:0] kbd_byte,
    output logic [BYTE_W-1:0] rdata,
    output logic              kbd_take,
    output logic              see_high
);
    logic [NIB_W-1:0] picked;

    assign picked = view.sel_high ? high_nib : low_nib;

    // Per-port data selection.
    always_comb begin
        unique case (port_sel_e'(sel))
            PSEL_A:  rdata = view.kbd_disable ? {high_nib, low_nib} : kbd_byte;
            PSEL_B:  rdata = ctrl_q;
            PSEL_C:  rdata = {{(BYTE_W-NIB_W){1'b0}}, picked};
            default: rdata = '0;
        endcase
    end

    // Side effects of a read: keyboard consume and high-bank visibility.
    always_comb begin
        kbd_take = rd && (sel == PSEL_A) && !view.kbd_disable;
        see_high = rd && ((sel == PSEL_A) || (sel == PSEL_C && view.sel_high));
    end

    // R7
    portc_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == PSEL_C) |-> rdata[BYTE_W-1:NIB_W] == '0);
    // R3
    kbd_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_take |-> (rd && ctrl_q[7] == 1'b0 && rdata == kbd_byte));
endmodule

// File: rtl/sys_cfg_port.sv
// Top of the system configuration port handler: connects the control register,
// the switch banks and the read path. Assumes one bus access per cycle.
module sys_cfg_port
    import sys_cfg_pkg::*;
#(
    parameter int         DRIVES   = 2,
    parameter logic [1:0] VIDEO    = 2'b10,
    parameter logic [1:0] RAM_CODE = 2'b11,
    parameter bit         HAS_FPU  = 1'b0
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] kbd_byte,
    output logic       kbd_take,
    output logic [1:0] kbd_mode,
    output logic       spk_gate,
    output logic       spk_data_en,
    input  logic       hint_valid,
    input  logic       hint_composite
);
    logic [BYTE_W-1:0] ctrl_q;
    ctrl_view_t        view;
    logic [NIB_W-1:0]  high_nib, low_nib;
    logic              see_high, observed, wr_b;

    assign wr_b = bus_wr && (bus_sel == PSEL_B);

    sys_cfg_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_b(wr_b), .wdata(bus_wdata),
        .ctrl_q(ctrl_q), .view(view)
    );

    sys_cfg_switches #(
        .DRIVES(DRIVES), .VIDEO(VIDEO), .RAM_CODE(RAM_CODE), .HAS_FPU(HAS_FPU)
    ) u_sw (
        .clk(clk), .rst_n(rst_n), .see_high(see_high),
        .hint_valid(hint_valid), .hint_composite(hint_composite),
        .high_nib(high_nib), .low_nib(low_nib), .observed(observed)
    );

    sys_cfg_read_mux u_rd (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(bus_sel),
        .ctrl_q(ctrl_q), .view(view), .high_nib(high_nib), .low_nib(low_nib),
        .kbd_byte(kbd_byte), .rdata(bus_rdata), .kbd_take(kbd_take),
        .see_high(see_high)
    );

    // Outputs toward the keyboard controller and speaker.
    always_comb begin
        kbd_mode    = view.kbd_mode;
        spk_gate    = view.spk_gate;
        spk_data_en = view.spk_data_en;
    end

    // R2
    outputs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> (kbd_mode == $past(bus_wdata[7:6]) && spk_gate == $past(bus_wdata[0])
                  && spk_data_en == $past(bus_wdata[1])));
endmodule

// File: tb/sys_cfg_port_tb.sv
module sys_cfg_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] bus_sel = 2'd3;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, kbd_byte = '0;
    logic hint_valid = 1'b0, hint_composite = 1'b0;
    logic [7:0] rdata, rdata_m;
    logic take, take_m, gate, gate_m, den, den_m;
    logic [1:0] mode, mode_m;

    int n_cmp = 0, n_bad = 0;
    logic [8:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    sys_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .kbd_byte(kbd_byte), .kbd_take(take),
        .kbd_mode(mode), .spk_gate(gate), .spk_data_en(den),
        .hint_valid(hint_valid), .hint_composite(hint_composite));

    sys_cfg_port #(.DRIVES(1), .VIDEO(2'b11)) u_mono (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .kbd_byte(kbd_byte), .kbd_take(take_m),
        .kbd_mode(mode_m), .spk_gate(gate_m), .spk_data_en(den_m),
        .hint_valid(hint_valid), .hint_composite(hint_composite));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: for each read cycle, pop the expected {strobe, data} and compare.
    always begin
        @(posedge clk);
        #15;
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard: actual %h expected none", {take, rdata});
            end else begin
                check(tag_q.pop_front(), 16'({take, rdata}), 16'(exp_q.pop_front()));
            end
        end
    end

    task automatic do_reset();
        @(posedge clk); #2 rst_n = 1'b0;
        @(posedge clk); #2 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] p, input logic [7:0] d);
        @(posedge clk); #2 bus_wr = 1'b1; bus_sel = p; bus_wdata = d;
        @(posedge clk); #2 bus_wr = 1'b0; bus_sel = 2'd3;
    endtask

    task automatic rd(input logic [1:0] p, input logic [8:0] exp, input string tag);
        @(posedge clk); #2 bus_rd = 1'b1; bus_sel = p;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #2 bus_rd = 1'b0; bus_sel = 2'd3;
    endtask

    task automatic hint(input logic comp);
        @(posedge clk); #2 hint_valid = 1'b1; hint_composite = comp;
        @(posedge clk); #2 hint_valid = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        #5;
        // R1 reset values on the outputs
        check("R1 outputs", 16'({mode, gate, den}), 16'h0);
        rd(2'd1, 9'h000, "R1 portB");
        // R9 hint before observation: 80-col becomes composite 01 -> high = 0101
        hint(1'b1);
        wr(2'd1, 8'h88);
        @(posedge clk); #2 bus_rd = 1'b1; bus_sel = 2'd2;
        exp_q.push_back(9'h005); tag_q.push_back("R9 hint applied / R7 high bank");
        #11 check("R9 mono hint ignored", 16'(rdata_m), 16'h0003);
        @(posedge clk); #2 bus_rd = 1'b0; bus_sel = 2'd3;
        // R9 after port C high read (R8), hint ignored
        hint(1'b0);
        rd(2'd2, 9'h005, "R9 hint ignored after observe");
        // R4, R5, R6 switch byte: high 0101, low 1101
        rd(2'd0, 9'h05D, "R4 switches on port A");
        // R2 decode and readback
        wr(2'd1, 8'h43);
        #5 check("R2 outputs 43", 16'({mode, gate, den}), 16'b01_1_1);
        rd(2'd1, 9'h043, "R2 readback 43");
        wr(2'd1, 8'hC2);
        #5 check("R2 outputs C2", 16'({mode, gate, den}), 16'b11_0_1);
        // R10 writes to A and C ignored
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h00);
        rd(2'd1, 9'h0C2, "R10 portB unchanged");
        // R3 keyboard path with varied bytes
        wr(2'd1, 8'h40);
        kbd_byte = 8'hA5;
        rd(2'd0, 9'h1A5, "R3 kbd A5");
        kbd_byte = 8'h3C;
        rd(2'd0, 9'h13C, "R3 kbd 3C");
        // R7 low bank on port C
        rd(2'd2, 9'h00D, "R7 low bank");

        // R8: port A read sets observed, so a later hint is ignored
        do_reset();
        rd(2'd0, 9'h13C, "R3 kbd after reset");
        hint(1'b1);
        wr(2'd1, 8'h88);
        rd(2'd2, 9'h006, "R8 portA observes");

        // R8: low-bank port C read leaves flag clear, hint still applies
        do_reset();
        wr(2'd1, 8'h80);
        rd(2'd2, 9'h00D, "R7 low bank after reset");
        hint(1'b1);
        wr(2'd1, 8'h88);
        rd(2'd2, 9'h005, "R8 low read no observe");
        hint(1'b0);
        rd(2'd2, 9'h005, "R8 flag set by high read");

        // R9: a hint in the same cycle as a high read still applies
        do_reset();
        wr(2'd1, 8'h88);
        @(posedge clk); #2 bus_rd = 1'b1; bus_sel = 2'd2; hint_valid = 1'b1; hint_composite = 1'b1;
        exp_q.push_back(9'h006); tag_q.push_back("R9 same-cycle old value");
        @(posedge clk); #2 bus_rd = 1'b0; bus_sel = 2'd3; hint_valid = 1'b0;
        rd(2'd2, 9'h005, "R9 same-cycle hint applied");

        repeat (3) @(posedge clk);
        check("scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule